// File: doc/BRIEF.md
# Bus Bridge Warm-Reset Quiesce Handshake

This block controls a bridge between a system-side bus (clock domain A) and a peer-side bus (clock domain B). It lets the bridge be brought into a quiet, idle state without wiping its configuration registers. Software raises a level request. The bridge then stops taking new work, lets the transaction in flight on each side finish, and raises an acknowledge flag that software can poll. If a transaction does not finish within a programmable number of cycles, it is cut off with an error response so that the acknowledge can still arrive.

While the request is held, every new transaction on either side gets a one-cycle retry response. The same applies to accesses to the bridge's own configuration registers. Dropping the request restores normal service at once. A destructive hard reset, from either domain's reset pin or from a software bit, clears the configuration registers and all handshake state.

Each side's protocol engine is shown here as a small valid/done interface. The engine presents `valid` for one cycle per attempt and reports completion with `done`. The request travels to domain B through a two-flop synchronizer, and the peer side's idle flag travels back through a second one.

Top module: `bridge_quiesce`

## Requirements
- R1: After a hard reset, `quiesce_ack`, all accept/retry/abort pulses and `cfg_ok`/`cfg_retry` are 0, and every configuration register reads 0.
- R2: With no request, a side-A `a_valid` on an idle side gives an `a_accept` pulse one clock later. `a_done` ends the transaction. An `a_valid` while a transaction is outstanding gives `a_retry`.
- R3: While `quiesce_req` is 1, an `a_valid` gives an `a_retry` pulse one clock later and never an `a_accept`.
- R4: Once the request has crossed into domain B (two B clocks), a `b_valid` gives a `b_retry` pulse one clock later and never a `b_accept`.
- R5: While `quiesce_req` is 1, a configuration access gives a `cfg_retry` pulse one clock later and no `cfg_ok`, and a retried write leaves the register unchanged.
- R6: `quiesce_ack` stays 0 while a side-A transaction is outstanding. It rises within 8 clocks after that transaction's `a_done`.
- R7: When a transaction is still outstanding under the request, an `a_abort` pulse appears on the (`timeout_cycles`+1)-th clock edge after the request is raised, and `quiesce_ack` follows.
- R8: `quiesce_ack` returns to 0 one clock after `quiesce_req` is cleared. An `a_valid` presented in the same cycle the request is cleared is accepted.
- R9: A warm quiesce and release leaves every configuration register value intact.
- R10: A hard reset from `rst_a_pin` or from `soft_hard_rst` clears every configuration register.
- R11: With no request, a configuration write or read gives a `cfg_ok` pulse one clock later. For a read, `cfg_rdata` holds the addressed register's value in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | System-side clock |
| rst_a_pin | input | 1 | Synchronous active-high hard reset pin, domain A |
| clk_b | input | 1 | Peer-side clock |
| rst_b_pin | input | 1 | Synchronous active-high hard reset pin, domain B |
| soft_hard_rst | input | 1 | Software hard-reset bit (domain A), resets both halves |
| quiesce_req | input | 1 | Software warm-reset request level (domain A) |
| timeout_cycles | input | TO_W | Drain timeout limit, quasi-static |
| quiesce_ack | output | 1 | Quiesce complete flag (domain A) |
| a_valid | input | 1 | New system-side transaction attempt |
| a_done | input | 1 | System-side transaction finished |
| a_accept | output | 1 | System-side transaction accepted |
| a_retry | output | 1 | System-side transaction refused, retry |
| a_abort | output | 1 | System-side transaction aborted with error |
| b_valid | input | 1 | New peer-side transaction attempt |
| b_done | input | 1 | Peer-side transaction finished |
| b_accept | output | 1 | Peer-side transaction accepted |
| b_retry | output | 1 | Peer-side transaction refused, retry |
| b_abort | output | 1 | Peer-side transaction aborted with error |
| cfg_valid | input | 1 | Configuration register access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | AW | Configuration register index |
| cfg_wdata | input | DW | Configuration write data |
| cfg_rdata | output | DW | Configuration read data |
| cfg_ok | output | 1 | Configuration access completed |
| cfg_retry | output | 1 | Configuration access refused, retry |

## Verification
One attack targets the drain. A transaction is left open under the request, and the bench checks that the acknowledge stays low until `a_done`. A design that acknowledged at once would report idle with traffic still on the bus. A second test leaves a transaction stalled and counts edges up to the abort pulse. An off-by-one limit compare shifts that count, and a missing timeout leaves the acknowledge low forever. The remaining tests write a configuration register during the request and read it back after release, to catch a write that slips through the retry. They also present a transaction in the very cycle the request drops, to catch a release that lags by a cycle. Both hard-reset sources are checked for wiping the registers, and the warm path is checked for keeping them.

// File: rtl/bq_pkg.sv
package bq_pkg;
  typedef struct packed {
    logic accept;
    logic retry;
    logic abort;
  } bq_resp_t;
endpackage

// File: rtl/bq_sync2.sv
module bq_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/bq_side_gate.sv
module bq_side_gate
  import bq_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            quiesce,
  input  logic [TO_W-1:0] timeout_cycles,
  input  logic            tx_valid,
  input  logic            tx_done,
  output bq_resp_t        resp,
  output logic            busy,
  output logic            drained
);
  logic [TO_W-1:0] wait_cnt, wait_cnt_n;
  logic            busy_n;
  bq_resp_t        resp_n;

  always_comb begin
    busy_n     = busy;
    wait_cnt_n = '0;
    resp_n     = '0;
    if (tx_valid) begin
      if (quiesce || busy) resp_n.retry = 1'b1;
      else begin
        resp_n.accept = 1'b1;
        busy_n        = 1'b1;
      end
    end
    if (busy) begin
      if (tx_done) begin
        busy_n = 1'b0;
      end else if (quiesce) begin
        if (wait_cnt == timeout_cycles) begin
          resp_n.abort = 1'b1;
          busy_n       = 1'b0;
        end else begin
          wait_cnt_n = wait_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      wait_cnt <= '0;
      resp     <= '0;
      drained  <= 1'b0;
    end else begin
      busy     <= busy_n;
      wait_cnt <= wait_cnt_n;
      resp     <= resp_n;
      drained  <= quiesce && !busy_n;
    end
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    $countones({resp.accept, resp.retry}) <= 1); // R2
endmodule

// File: rtl/bq_cfg_regs.sv
module bq_cfg_regs #(
  parameter int N  = 4,
  parameter int DW = 32,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          valid,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ok,
  output logic          retry
);
  logic [DW-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
      rdata <= '0;
      ok    <= 1'b0;
      retry <= 1'b0;
    end else begin
      ok    <= valid && !hold;
      retry <= valid && hold;
      if (valid && !hold) begin
        if (write) regs[addr] <= wdata;
        else       rdata      <= regs[addr];
      end
    end
  end

  AST_CFG_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ok && retry)); // R11
endmodule

// File: rtl/bridge_quiesce.sv
module bridge_quiesce
  import bq_pkg::*;
#(
  parameter int TO_W  = 16,
  parameter int CFG_N = 4,
  parameter int DW    = 32,
  localparam int AW   = (CFG_N > 1) ? $clog2(CFG_N) : 1
) (
  input  logic            clk_a,
  input  logic            rst_a_pin,
  input  logic            clk_b,
  input  logic            rst_b_pin,
  input  logic            soft_hard_rst,
  input  logic            quiesce_req,
  input  logic [TO_W-1:0] timeout_cycles,
  output logic            quiesce_ack,
  input  logic            a_valid,
  input  logic            a_done,
  output logic            a_accept,
  output logic            a_retry,
  output logic            a_abort,
  input  logic            b_valid,
  input  logic            b_done,
  output logic            b_accept,
  output logic            b_retry,
  output logic            b_abort,
  input  logic            cfg_valid,
  input  logic            cfg_write,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  output logic            cfg_ok,
  output logic            cfg_retry
);
  logic rst_a, rst_b, soft_rst_b;
  logic req_b, drained_a, drained_b, drained_b_s;
  logic busy_a, busy_b;
  bq_resp_t resp_a, resp_b;

  assign rst_a = rst_a_pin || soft_hard_rst;

  bq_sync2 #(.W(1)) u_soft_to_b (
    .clk(clk_b), .rst(rst_b_pin), .d(soft_hard_rst), .q(soft_rst_b));
  assign rst_b = rst_b_pin || soft_rst_b;

  bq_sync2 #(.W(1)) u_req_to_b (
    .clk(clk_b), .rst(rst_b), .d(quiesce_req), .q(req_b));

  bq_sync2 #(.W(1)) u_idle_to_a (
    .clk(clk_a), .rst(rst_a), .d(drained_b), .q(drained_b_s));

  bq_side_gate #(.TO_W(TO_W)) u_gate_a (
    .clk(clk_a), .rst(rst_a), .quiesce(quiesce_req),
    .timeout_cycles(timeout_cycles), .tx_valid(a_valid), .tx_done(a_done),
    .resp(resp_a), .busy(busy_a), .drained(drained_a));

  bq_side_gate #(.TO_W(TO_W)) u_gate_b (
    .clk(clk_b), .rst(rst_b), .quiesce(req_b),
    .timeout_cycles(timeout_cycles), .tx_valid(b_valid), .tx_done(b_done),
    .resp(resp_b), .busy(busy_b), .drained(drained_b));

  bq_cfg_regs #(.N(CFG_N), .DW(DW)) u_cfg (
    .clk(clk_a), .rst(rst_a), .hold(quiesce_req), .valid(cfg_valid),
    .write(cfg_write), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .ok(cfg_ok), .retry(cfg_retry));

  assign a_accept = resp_a.accept;
  assign a_retry  = resp_a.retry;
  assign a_abort  = resp_a.abort;
  assign b_accept = resp_b.accept;
  assign b_retry  = resp_b.retry;
  assign b_abort  = resp_b.abort;

  always_ff @(posedge clk_a) begin
    if (rst_a) quiesce_ack <= 1'b0;
    else       quiesce_ack <= quiesce_req && drained_a && !busy_a && drained_b_s;
  end

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk_a) disable iff (rst_a)
    quiesce_ack |-> $past(quiesce_req)); // R8
  AST_ACK_ONLY_IDLE: assert property (@(posedge clk_a) disable iff (rst_a)
    quiesce_ack |-> !busy_a); // R6
  AST_ACK_DROPS: assert property (@(posedge clk_a) disable iff (rst_a)
    $fell(quiesce_req) |=> !quiesce_ack); // R8
  AST_NO_ACCEPT_AT_ACK: assert property (@(posedge clk_a) disable iff (rst_a)
    quiesce_ack |-> !a_accept); // R3
  AST_CFG_HELD_AT_ACK: assert property (@(posedge clk_a) disable iff (rst_a)
    quiesce_ack |-> !cfg_ok); // R5
endmodule

// File: tb/bridge_quiesce_bench.sv
module bridge_quiesce_bench;
  localparam int TO_W = 16, CFG_N = 4, DW = 32, AW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_a_pin, rst_b_pin, soft_hard_rst, quiesce_req;
  logic [TO_W-1:0] timeout_cycles;
  logic quiesce_ack;
  logic a_valid, a_done, a_accept, a_retry, a_abort;
  logic b_valid, b_done, b_accept, b_retry, b_abort;
  logic cfg_valid, cfg_write, cfg_ok, cfg_retry;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_wdata, cfg_rdata;

  int checks = 0, failures = 0;
  bit finished = 0;

  bridge_quiesce #(.TO_W(TO_W), .CFG_N(CFG_N), .DW(DW)) u_bridge_quiesce (
    .clk_a(clk), .rst_a_pin(rst_a_pin), .clk_b(clk), .rst_b_pin(rst_b_pin),
    .soft_hard_rst(soft_hard_rst), .quiesce_req(quiesce_req),
    .timeout_cycles(timeout_cycles), .quiesce_ack(quiesce_ack),
    .a_valid(a_valid), .a_done(a_done), .a_accept(a_accept), .a_retry(a_retry),
    .a_abort(a_abort), .b_valid(b_valid), .b_done(b_done), .b_accept(b_accept),
    .b_retry(b_retry), .b_abort(b_abort), .cfg_valid(cfg_valid),
    .cfg_write(cfg_write), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_ok(cfg_ok), .cfg_retry(cfg_retry));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg_access(input bit wr, input logic [AW-1:0] ad, input logic [DW-1:0] wd,
                            output bit ok, output bit rty, output logic [DW-1:0] rd);
    cfg_valid = 1; cfg_write = wr; cfg_addr = ad; cfg_wdata = wd;
    @(negedge clk);
    cfg_valid = 0;
    ok = cfg_ok; rty = cfg_retry; rd = cfg_rdata;
  endtask

  task automatic a_start(output bit acc, output bit rty);
    a_valid = 1;
    @(negedge clk);
    a_valid = 0;
    acc = a_accept; rty = a_retry;
  endtask

  task automatic wait_ack(output int n);
    n = 0;
    while (!quiesce_ack && n < 40) begin @(negedge clk); n++; end
  endtask

  task automatic release_req();
    quiesce_req = 0;
    cyc(6);
  endtask

  task automatic t_reset();
    bit ok, rty; logic [DW-1:0] rd;
    check(quiesce_ack == 0 && a_accept == 0 && a_retry == 0 && a_abort == 0 &&
          b_accept == 0 && b_retry == 0 && b_abort == 0 && cfg_ok == 0 && cfg_retry == 0,
          "R1 outputs idle", quiesce_ack, 0);
    for (int i = 0; i < CFG_N; i++) begin
      cfg_access(0, AW'(i), '0, ok, rty, rd);
      check(ok && rd == 0, "R1 cfg reads zero", rd, 0);
    end
  endtask

  task automatic t_cfg_normal();
    bit ok, rty; logic [DW-1:0] rd;
    cfg_access(1, 2'd1, 32'hA5A5_0001, ok, rty, rd);
    check(ok && !rty, "R11 write ok", ok, 1);
    cfg_access(1, 2'd3, 32'h0000_BEEF, ok, rty, rd);
    cfg_access(0, 2'd1, '0, ok, rty, rd);
    check(ok && rd == 32'hA5A5_0001, "R11 read reg1", rd, 32'hA5A5_0001);
    cfg_access(0, 2'd3, '0, ok, rty, rd);
    check(ok && rd == 32'h0000_BEEF, "R11 read reg3", rd, 32'h0000_BEEF);
  endtask

  task automatic t_normal_a();
    bit acc, rty;
    a_start(acc, rty);
    check(acc && !rty, "R2 accept when idle", acc, 1);
    a_start(acc, rty);
    check(!acc && rty, "R2 retry while busy", rty, 1);
    a_done = 1; cyc(1); a_done = 0;
    a_start(acc, rty);
    check(acc, "R2 accept after done", acc, 1);
    a_done = 1; cyc(1); a_done = 0;
    b_valid = 1; cyc(1); b_valid = 0;
    check(b_accept, "R2 peer side accept", b_accept, 1);
    b_done = 1; cyc(1); b_done = 0;
  endtask

  task automatic t_quiesce_idle();
    bit acc, rty, ok; logic [DW-1:0] rd; int n;
    quiesce_req = 1;
    a_start(acc, rty);
    check(!acc && rty, "R3 side A retry", rty, 1);
    cyc(3);
    b_valid = 1; cyc(1); b_valid = 0;
    check(b_retry && !b_accept, "R4 side B retry", b_retry, 1);
    cfg_access(1, 2'd1, 32'hDEAD_DEAD, ok, rty, rd);
    check(rty && !ok, "R5 cfg retry", rty, 1);
    wait_ack(n);
    check(quiesce_ack, "R6 ack when idle", quiesce_ack, 1);
    quiesce_req = 0; a_valid = 1;
    @(negedge clk); a_valid = 0;
    check(!quiesce_ack, "R8 ack drops next cycle", quiesce_ack, 0);
    check(a_accept, "R8 accept in release cycle", a_accept, 1);
    a_done = 1; cyc(1); a_done = 0;
    cyc(6);
    cfg_access(0, 2'd1, '0, ok, rty, rd);
    check(rd == 32'hA5A5_0001, "R5 retried write ignored / R9 kept", rd, 32'hA5A5_0001);
    cfg_access(0, 2'd3, '0, ok, rty, rd);
    check(rd == 32'h0000_BEEF, "R9 warm keeps reg3", rd, 32'h0000_BEEF);
  endtask

  task automatic t_drain();
    bit acc, rty; int n; bit early = 0;
    timeout_cycles = 16'd500;
    a_start(acc, rty);
    quiesce_req = 1;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (quiesce_ack) early = 1; end
    check(!early, "R6 no ack while outstanding", early, 0);
    a_done = 1; cyc(1); a_done = 0;
    wait_ack(n);
    check(quiesce_ack && n <= 8, "R6 ack after done", n, 8);
    release_req();
  endtask

  task automatic t_timeout();
    bit acc, rty; int n = 0; int got = -1;
    timeout_cycles = 16'd5;
    a_start(acc, rty);
    quiesce_req = 1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (a_abort && got < 0) got = i;
    end
    check(got == 6, "R7 abort edge", got, 6);
    wait_ack(n);
    check(quiesce_ack, "R7 ack after abort", quiesce_ack, 1);
    release_req();
  endtask

  task automatic t_hard();
    bit ok, rty; logic [DW-1:0] rd;
    cfg_access(1, 2'd2, 32'h1234_5678, ok, rty, rd);
    soft_hard_rst = 1; cyc(4); soft_hard_rst = 0; cyc(3);
    cfg_access(0, 2'd2, '0, ok, rty, rd);
    check(ok && rd == 0, "R10 soft hard reset clears", rd, 0);
    cfg_access(1, 2'd0, 32'h0BAD_F00D, ok, rty, rd);
    rst_a_pin = 1; cyc(2); rst_a_pin = 0; cyc(1);
    cfg_access(0, 2'd0, '0, ok, rty, rd);
    check(ok && rd == 0, "R10 pin reset clears", rd, 0);
  endtask

  initial begin
    rst_a_pin = 1; rst_b_pin = 1; soft_hard_rst = 0; quiesce_req = 0;
    timeout_cycles = 16'd500;
    a_valid = 0; a_done = 0; b_valid = 0; b_done = 0;
    cfg_valid = 0; cfg_write = 0; cfg_addr = '0; cfg_wdata = '0;
    cyc(4);
    rst_a_pin = 0; rst_b_pin = 0;
    cyc(1);
    t_reset();
    t_cfg_normal();
    t_normal_a();
    t_quiesce_idle();
    t_drain();
    t_timeout();
    t_hard();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule